// File: doc/BRIEF.md
# Two-Input Fuzzy Temperature Controller

This block turns two crisp temperature readings into one crisp set-point temperature by fuzzy inference. Each reading, in degrees from 0 to 500, is graded against three shared overlapping sets: Low, Mid and High. Eight fixed rules pair a grade of the first reading with a grade of the second and name an output set. A rule fires with the smaller of its two grades. Rules that name the same output set are merged by taking the larger strength, and the result goes into a strength register kept for each output set.

A one-cycle `start` pulse loads both readings and folds the new rule strengths into the three registers. The block then forms the weighted mean of the output sets' representative temperatures, using the register contents as weights. A shift-and-subtract divider computes the mean over several cycles, and `done` pulses when the quotient is ready. The registers keep their contents from one run to the next, so a caller can merge several runs. Raising `clr_buf` empties them, either on its own or together with `start` to begin a fresh run.

Top module: `fuzzy_temp_ctl`

## Requirements
- R1: Grades are 8-bit, with 255 meaning full membership. ramp(d) = floor((d*466 + 128)/256). For t <= 70, Low = 255 and the other two grades are 0. For 70 < t < 210, Mid = ramp(t-70) and Low = 255-Mid. For 210 <= t < 350, High = ramp(t-210) and Mid = 255-High. For t >= 350, High = 255.
- R2: A reading never has non-zero Low and non-zero High at the same time, so at most two adjacent sets are graded above zero.
- R3: Each rule's strength is the minimum of its two grades. The rules are: first-Low/second-Low→High, Low/Mid→Mid, Low/High→Low, Mid/Low→High, Mid/High→Low, High/Low→High, High/Mid→Mid, High/High→Low. No rule covers Mid/Mid.
- R4: Each output set's strength is the maximum over its rules. It is merged by maximum into that set's register, and the register keeps the value across runs until it is cleared.
- R5: `clr_buf` alone empties all three registers. When `clr_buf` arrives in the same cycle as an accepted `start`, the registers take only the new strengths.
- R6: `result` = floor((70*SL + 210*SM + 350*SH) / (SL + SM + SH)), where SL, SM and SH are the register values after the merge.
- R7: If all three registers are zero after the merge, `result` is 0, `no_fire` is 1, and `done` rises after the second rising edge, counting the edge that sampled `start` as the first.
- R8: Otherwise `done` is high for exactly one cycle after the 21st rising edge, counting the edge that sampled `start` as the first, and `no_fire` is 0. `result` and `no_fire` change only when `done` rises and hold their values in between.
- R9: A `start` pulse that arrives while a run is in progress is ignored and does not change the registers.
- R10: After reset, `done`, `no_fire`, `result` and all three registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Starts a run when idle |
| clr_buf | input | 1 | Empties the strength registers |
| temp_a | input | 9 | First temperature reading in degrees |
| temp_b | input | 9 | Second temperature reading in degrees |
| done | output | 1 | One-cycle pulse when the result is ready |
| result | output | 9 | Crisp set-point temperature in degrees |
| no_fire | output | 1 | Set when no rule fired in the last run |

## Verification
The clear and the merge can fall in the same cycle when `clr_buf` and `start` are raised together. The bench first fills the registers with a High strength. It then starts a High/High run with the clear raised and expects exactly 70. If stale High strength had survived, the result would be pulled up to 210. A second pair of runs, merged without a clear, shows that the merge on its own does keep the old strength.

// File: rtl/fuzzy_temp_ctl.sv
module fuzzy_temp_ctl #(
  parameter int TW = 9,
  parameter int MW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          clr_buf,
  input  logic [TW-1:0] temp_a,
  input  logic [TW-1:0] temp_b,
  output logic          done,
  output logic [TW-1:0] result,
  output logic          no_fire
);
  localparam logic [TW-1:0] PT_LO  = TW'(70);
  localparam logic [TW-1:0] PT_MID = TW'(210);
  localparam logic [TW-1:0] PT_HI  = TW'(350);
  localparam logic [MW-1:0] FULL   = '1;
  localparam int SEG   = 140;
  localparam int SLOPE = ((1 << MW) - 1) * 256 / SEG;
  localparam int PW    = MW + TW;
  localparam int DW    = $clog2(3 * ((1 << MW) - 1) + 1);
  localparam int NW    = $clog2(350 * 3 * ((1 << MW) - 1) + 1);
  localparam int CW    = $clog2(NW);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_DIV} st_t;

  function automatic logic [MW-1:0] ramp(input logic [TW-1:0] d);
    logic [PW-1:0] p;
    p = PW'(d) * PW'(SLOPE) + PW'(128);
    return p[MW+7:8];
  endfunction

  function automatic logic [3*MW-1:0] grade(input logic [TW-1:0] t);
    logic [MW-1:0] l, m, h;
    if (t <= PT_LO) begin
      l = FULL; m = '0; h = '0;
    end else if (t < PT_MID) begin
      m = ramp(t - PT_LO); l = FULL - m; h = '0;
    end else if (t < PT_HI) begin
      h = ramp(t - PT_MID); m = FULL - h; l = '0;
    end else begin
      l = '0; m = '0; h = FULL;
    end
    return {h, m, l};
  endfunction

  function automatic logic [MW-1:0] mn(input logic [MW-1:0] x, input logic [MW-1:0] y);
    return (x < y) ? x : y;
  endfunction

  function automatic logic [MW-1:0] mx(input logic [MW-1:0] x, input logic [MW-1:0] y);
    return (x > y) ? x : y;
  endfunction

  st_t           state;
  logic [MW-1:0] buf_l, buf_m, buf_h;
  logic [NW-1:0] quo;
  logic [DW-1:0] rem, dvs;
  logic [CW-1:0] cnt;

  logic [MW-1:0] a_l, a_m, a_h, b_l, b_m, b_h;
  assign {a_h, a_m, a_l} = grade(temp_a);
  assign {b_h, b_m, b_l} = grade(temp_b);

  logic [MW-1:0] r_h, r_m, r_l;
  assign r_h = mx(mx(mn(a_l, b_l), mn(a_m, b_l)), mn(a_h, b_l));
  assign r_m = mx(mn(a_l, b_m), mn(a_h, b_m));
  assign r_l = mx(mx(mn(a_l, b_h), mn(a_m, b_h)), mn(a_h, b_h));

  logic          go;
  logic [MW-1:0] base_l, base_m, base_h;
  assign go     = (state == S_IDLE) && start;
  assign base_l = clr_buf ? '0 : buf_l;
  assign base_m = clr_buf ? '0 : buf_m;
  assign base_h = clr_buf ? '0 : buf_h;

  logic [NW-1:0] num;
  logic [DW-1:0] den;
  assign num = NW'(buf_l) * NW'(PT_LO) + NW'(buf_m) * NW'(PT_MID) + NW'(buf_h) * NW'(PT_HI);
  assign den = DW'(buf_l) + DW'(buf_m) + DW'(buf_h);

  logic [DW:0]   sh, diff;
  logic          ge;
  logic [DW-1:0] rem_n;
  logic [NW-1:0] quo_n;
  assign sh    = {rem, quo[NW-1]};
  assign diff  = sh - {1'b0, dvs};
  assign ge    = sh >= {1'b0, dvs};
  assign rem_n = ge ? diff[DW-1:0] : sh[DW-1:0];
  assign quo_n = {quo[NW-2:0], ge};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_l <= '0; buf_m <= '0; buf_h <= '0;
    end else if (go) begin
      buf_l <= mx(base_l, r_l);
      buf_m <= mx(base_m, r_m);
      buf_h <= mx(base_h, r_h);
    end else if (clr_buf) begin
      buf_l <= '0; buf_m <= '0; buf_h <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      quo     <= '0;
      rem     <= '0;
      dvs     <= '0;
      cnt     <= '0;
      done    <= 1'b0;
      result  <= '0;
      no_fire <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (go) state <= S_LOAD;
        S_LOAD: begin
          if (den == '0) begin
            result  <= '0;
            no_fire <= 1'b1;
            done    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            quo   <= num;
            rem   <= '0;
            dvs   <= den;
            cnt   <= CW'(NW - 1);
            state <= S_DIV;
          end
        end
        S_DIV: begin
          quo <= quo_n;
          rem <= rem_n;
          if (cnt == '0) begin
            result  <= quo_n[TW-1:0];
            no_fire <= 1'b0;
            done    <= 1'b1;
            state   <= S_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    assert_adjacent_a_R2: assert (!(a_l != '0 && a_h != '0));
    assert_adjacent_b_R2: assert (!(b_l != '0 && b_h != '0));
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done);
  assert_nofire_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    no_fire |-> (result == '0));
  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result <= PT_HI);
  assert_keep_max_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_buf |=> (buf_h >= $past(buf_h)) && (buf_m >= $past(buf_m)) && (buf_l >= $past(buf_l)));
  assert_busy_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && !clr_buf) |=> $stable(buf_h) && $stable(buf_m) && $stable(buf_l));
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state == S_IDLE));

endmodule

// File: tb/sim_fuzzy_temp_ctl.sv
module sim_fuzzy_temp_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       clr_buf = 1'b0;
  logic [8:0] temp_a = '0;
  logic [8:0] temp_b = '0;
  logic       done;
  logic [8:0] result;
  logic       no_fire;

  int checks = 0;
  int errors = 0;
  int m_l = 0, m_m = 0, m_h = 0;

  always #5 clk = ~clk;

  fuzzy_temp_ctl u0 (.clk(clk), .rst_n(rst_n), .start(start), .clr_buf(clr_buf),
                     .temp_a(temp_a), .temp_b(temp_b), .done(done),
                     .result(result), .no_fire(no_fire));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int rmp(input int d);
    return (d * 466 + 128) / 256;
  endfunction

  function automatic int gr(input int t, input int s);
    int l, m, h;
    if (t <= 70) begin l = 255; m = 0; h = 0; end
    else if (t < 210) begin m = rmp(t - 70); l = 255 - m; h = 0; end
    else if (t < 350) begin h = rmp(t - 210); m = 255 - h; l = 0; end
    else begin l = 0; m = 0; h = 255; end
    return (s == 0) ? l : (s == 1) ? m : h;
  endfunction

  function automatic int mn(input int x, input int y);
    return (x < y) ? x : y;
  endfunction

  function automatic int mx(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

  // R1 grades, R3 rule table, R4 merge, R5 clear, R6 mean: expected value
  function automatic int model(input int a, input int b, input bit clr);
    int al, am, ah, bl, bm, bh, sh, sm, sl, den;
    al = gr(a, 0); am = gr(a, 1); ah = gr(a, 2);
    bl = gr(b, 0); bm = gr(b, 1); bh = gr(b, 2);
    sh = mx(mx(mn(al, bl), mn(am, bl)), mn(ah, bl));
    sm = mx(mn(al, bm), mn(ah, bm));
    sl = mx(mx(mn(al, bh), mn(am, bh)), mn(ah, bh));
    if (clr) begin m_l = 0; m_m = 0; m_h = 0; end
    m_l = mx(m_l, sl); m_m = mx(m_m, sm); m_h = mx(m_h, sh);
    den = m_l + m_m + m_h;
    return (den == 0) ? -1 : (70 * m_l + 210 * m_m + 350 * m_h) / den;
  endfunction

  task automatic wait_done(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
      start = 1'b0; clr_buf = 1'b0;
    end while (!done && n < 200);
  endtask

  task automatic run_case(input string tag, input int a, input int b, input bit clr);
    int exp, n;
    exp = model(a, b, clr);
    @(negedge clk);
    temp_a = 9'(a); temp_b = 9'(b); clr_buf = clr; start = 1'b1;
    wait_done(n);
    if (exp < 0) begin
      chk({tag, " R7 result"}, int'(result), 0);
      chk("R7 no_fire", int'(no_fire), 1);
      chk("R7 latency", n, 2);
    end else begin
      chk(tag, int'(result), exp);
      chk("R8 no_fire", int'(no_fire), 0);
      chk("R8 latency", n, 21);
    end
    @(negedge clk);
    chk("R8 pulse", int'(done), 0);
  endtask

  task automatic test_reset();
    chk("R10 done", int'(done), 0);
    chk("R10 result", int'(result), 0);
    chk("R10 no_fire", int'(no_fire), 0);
    run_case("R10 empty-regs", 210, 210, 1'b0);
  endtask

  task automatic test_mixed();
    run_case("R3 low-low", 0, 0, 1'b1);
    run_case("R3 high-high", 500, 500, 1'b1);
    run_case("R1 mid/high ramp", 100, 300, 1'b1);
    run_case("R2 two sets", 150, 80, 1'b1);
    run_case("R1 breakpoints", 350, 70, 1'b1);
    run_case("R1 ramp ends", 71, 209, 1'b1);
    run_case("R3 high-mid", 420, 230, 1'b1);
    run_case("R6 mix", 180, 60, 1'b1);
  endtask

  task automatic test_merge_clear();
    run_case("R4 seed", 0, 0, 1'b1);
    run_case("R4 merge keeps old", 500, 500, 1'b0);
    run_case("R5 clear with start", 500, 500, 1'b1);
    @(negedge clk); clr_buf = 1'b1;
    @(negedge clk); clr_buf = 1'b0;
    m_l = 0; m_m = 0; m_h = 0;
    run_case("R5 clear alone", 0, 0, 1'b0);
  endtask

  task automatic test_busy();
    int n, exp;
    exp = model(0, 0, 1'b1);
    @(negedge clk);
    temp_a = 9'd0; temp_b = 9'd0; clr_buf = 1'b1; start = 1'b1;
    @(negedge clk); start = 1'b0; clr_buf = 1'b0;
    repeat (4) @(negedge clk);
    temp_a = 9'd0; temp_b = 9'd500; start = 1'b1;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 200) begin @(negedge clk); n++; end
    chk("R9 busy run", int'(result), exp);
    @(negedge clk);
    run_case("R9 no merge", 0, 0, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_mixed();
    test_merge_clear();
    test_busy();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    errors++;
    $display("FAIL R8 watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule